// File: doc/BRIEF.md
# Mains Zero-Crossing Phase Monitor

This block follows a digital zero-crossing level that changes state at every half-cycle of the AC mains. It synchronises that level to the local clock. Every change of level, whether rising or falling, produces a one-cycle event strobe. A counter advanced by an external one-microsecond tick measures the time between consecutive events. Each completed interval is held on an output and judged against two windows. The framing window catches intervals that are too short or too long after a transmitted pulse. The acceptance window, from 90 % to 110 % of the nominal half-cycle, decides whether the line is in specification.

The nominal half-cycle is chosen by a parameter: 8333 µs for 60 Hz mains or 10000 µs for 50 Hz mains. If no event arrives within the timeout (250 ms by default), the counter stops at that limit and a timeout flag rises. The timeout also withdraws the in-spec verdict. A controller that transmits on the mains can use the strobe as its bit clock. It can treat a timeout or a framing fault as loss of sync.

Top module: `zc_phase_monitor`

## Requirements
- R1: While reset is high and in the cycle after it is released, edge_o, interval_o, timeout_o, fault_o and in_spec_o are all 0.
- R2: A change of zc_i first sampled at rising clock edge k raises edge_o for exactly one cycle, the cycle that follows rising edge k+1. This holds for a 0-to-1 change and for a 1-to-0 change.
- R3: On every strobe except the first after reset, interval_o loads the number of cycles with tick_i high that lie strictly between the previous strobe cycle and this one. The new value is visible from the cycle after the strobe. Otherwise interval_o holds its value.
- R4: Cycles with tick_i low do not advance the interval count. An interval with no tick at all reports 0.
- R5: The interval count saturates at TIMEOUT_US. A longer interval reports exactly TIMEOUT_US.
- R6: timeout_o is 1 exactly while the count since the last strobe (or since reset) equals TIMEOUT_US. It returns to 0 in the cycle after the next strobe.
- R7: On every strobe except the first after reset, fault_o is set to 1 if the measured interval is below FAULT_MIN_US or above FAULT_MAX_US, and to 0 otherwise. Both bounds themselves pass. fault_o holds between strobes.
- R8: On every strobe except the first after reset, in_spec_o is set to 1 if the measured interval lies within floor(H*90/100) to floor(H*110/100) inclusive, and to 0 otherwise. H is HALF_60_US when USE_50HZ is 0 and HALF_50_US when it is 1.
- R9: In a cycle where timeout_o is 1 and no strobe occurs, in_spec_o is cleared on the next clock edge.
- R10: The first strobe after reset leaves interval_o, fault_o and in_spec_o at 0.
- R11: If a strobe falls in the same cycle that timeout_o is 1, the strobe wins. interval_o loads TIMEOUT_US, fault_o and in_spec_o are judged on that value, and timeout_o is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| zc_i | input | 1 | Zero-crossing level, asynchronous to clk |
| tick_i | input | 1 | One-cycle pulse per microsecond |
| edge_o | output | 1 | One-cycle strobe for each level change |
| interval_o | output | CNT_W | Last measured half-cycle in microseconds |
| timeout_o | output | 1 | No level change within TIMEOUT_US |
| fault_o | output | 1 | Last interval outside the framing window |
| in_spec_o | output | 1 | Last interval within 90 % to 110 % of nominal |

## Verification
The strobe and the timeout can meet in one cycle. This happens when the gap between two level changes is one cycle longer than the timeout. The bench spaces two toggles of zc_i by exactly that many cycles, with a tick in every cycle. It then checks that edge_o and timeout_o are both high in the strobe cycle. In the following cycle timeout_o must be low, and interval_o must carry the saturated limit with fault_o set. A separate run lets the timeout occur with no strobe, then ends it with a late toggle. This shows the in-spec withdrawal and then the saturated capture.

// File: rtl/zcm_pkg.sv
package zcm_pkg;

  // Nominal half-cycle in microseconds for the selected mains frequency.
  function automatic int half_cycle_us(int h60, int h50, bit use50);
    return use50 ? h50 : h60;
  endfunction

  // Lower edge of the acceptance window (90 % of nominal, floored).
  function automatic int spec_low(int half);
    return (half * 90) / 100;
  endfunction

  // Upper edge of the acceptance window (110 % of nominal, floored).
  function automatic int spec_high(int half);
    return (half * 110) / 100;
  endfunction

  // Bits needed to count from zero up to lim.
  function automatic int count_width(int lim);
    return $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/zcm_edge_sync.sv
module zcm_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic zc_i,
  output logic edge_o
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= zc_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  // Either polarity of level change is an event.
  assign edge_o = sync_q ^ last_q;

  // R2: an event is followed by a cycle where the synchronised level is settled
  edge_settles_chk: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> (last_q == $past(sync_q)));
endmodule

// File: rtl/zcm_gap_counter.sv
module zcm_gap_counter #(
  parameter int LIMIT = 250000,
  parameter int W     = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         edge_i,
  output logic [W-1:0] count_o,
  output logic         timeout_o
);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;
  logic         at_limit;

  assign at_limit = (cnt_q == LIM);

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (edge_i)              cnt_q <= '0;
    else if (tick_i && !at_limit) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o   = cnt_q;
  assign timeout_o = at_limit;

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIM);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !edge_i) |=> $stable(cnt_q));

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    edge_i |=> (cnt_q == '0));
endmodule

// File: rtl/zcm_window_check.sv
module zcm_window_check #(
  parameter int W      = 18,
  parameter int FMIN   = 6000,
  parameter int FMAX   = 8500,
  parameter int SPEC_LO = 7499,
  parameter int SPEC_HI = 9166
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         edge_i,
  input  logic         timeout_i,
  input  logic [W-1:0] count_i,
  output logic [W-1:0] interval_o,
  output logic         fault_o,
  output logic         in_spec_o
);
  function automatic logic outside_frame(logic [W-1:0] v);
    return (int'(v) < FMIN) || (int'(v) > FMAX);
  endfunction

  function automatic logic inside_spec(logic [W-1:0] v);
    return (int'(v) >= SPEC_LO) && (int'(v) <= SPEC_HI);
  endfunction

  logic         armed_q;
  logic [W-1:0] interval_q;
  logic         fault_q, spec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q    <= 1'b0;
      interval_q <= '0;
      fault_q    <= 1'b0;
      spec_q     <= 1'b0;
    end else if (edge_i) begin
      armed_q <= 1'b1;
      if (armed_q) begin
        interval_q <= count_i;
        fault_q    <= outside_frame(count_i);
        spec_q     <= inside_spec(count_i);
      end
    end else if (timeout_i) begin
      spec_q <= 1'b0;
    end
  end

  assign interval_o = interval_q;
  assign fault_o    = fault_q;
  assign in_spec_o  = spec_q;

  // R3
  interval_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !edge_i |=> $stable(interval_q));

  // R7
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !edge_i |=> $stable(fault_q));

  // R9
  loss_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (timeout_i && !edge_i) |=> !spec_q);

  // R10
  first_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_i && !armed_q) |=> (interval_q == '0 && !fault_q && !spec_q));
endmodule

// File: rtl/zc_phase_monitor.sv
module zc_phase_monitor #(
  parameter int HALF_60_US   = 8333,
  parameter int HALF_50_US   = 10000,
  parameter bit USE_50HZ     = 1'b0,
  parameter int TIMEOUT_US   = 250000,
  parameter int FAULT_MIN_US = 6000,
  parameter int FAULT_MAX_US = 8500,
  localparam int CNT_W       = zcm_pkg::count_width(TIMEOUT_US)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zc_i,
  input  logic             tick_i,
  output logic             edge_o,
  output logic [CNT_W-1:0] interval_o,
  output logic             timeout_o,
  output logic             fault_o,
  output logic             in_spec_o
);
  localparam int HALF_US = zcm_pkg::half_cycle_us(HALF_60_US, HALF_50_US, USE_50HZ);
  localparam int SPEC_LO = zcm_pkg::spec_low(HALF_US);
  localparam int SPEC_HI = zcm_pkg::spec_high(HALF_US);

  logic             zc_event;
  logic             gap_expired;
  logic [CNT_W-1:0] gap_count;

  zcm_edge_sync u_sync (
    .clk    (clk),
    .rst    (rst),
    .zc_i   (zc_i),
    .edge_o (zc_event)
  );

  zcm_gap_counter #(
    .LIMIT (TIMEOUT_US),
    .W     (CNT_W)
  ) u_gap (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .edge_i    (zc_event),
    .count_o   (gap_count),
    .timeout_o (gap_expired)
  );

  zcm_window_check #(
    .W       (CNT_W),
    .FMIN    (FAULT_MIN_US),
    .FMAX    (FAULT_MAX_US),
    .SPEC_LO (SPEC_LO),
    .SPEC_HI (SPEC_HI)
  ) u_win (
    .clk        (clk),
    .rst        (rst),
    .edge_i     (zc_event),
    .timeout_i  (gap_expired),
    .count_i    (gap_count),
    .interval_o (interval_o),
    .fault_o    (fault_o),
    .in_spec_o  (in_spec_o)
  );

  assign edge_o    = zc_event;
  assign timeout_o = gap_expired;

  // R11: a strobe in a timeout cycle ends the timeout on the next edge
  edge_beats_timeout_chk: assert property (@(posedge clk) disable iff (rst)
    (zc_event && gap_expired) |=> !gap_expired);
endmodule

// File: tb/test_zc_phase_monitor.sv
`timescale 1ns/1ps
module test_zc_phase_monitor;
  localparam int W     = 9;    // enough for a limit of 300
  localparam int TMO   = 300;
  localparam int F_MIN = 72;
  localparam int F_MAX = 102;
  // nominal 100: acceptance 90..110

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic zc = 1'b0;
  logic tick = 1'b1;
  logic edge_s, tmo_s, fault_s, spec_s;
  logic [W-1:0] intv_s;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  zc_phase_monitor #(
    .HALF_60_US   (100),
    .HALF_50_US   (120),
    .USE_50HZ     (1'b0),
    .TIMEOUT_US   (TMO),
    .FAULT_MIN_US (F_MIN),
    .FAULT_MAX_US (F_MAX)
  ) i_zc_phase_monitor (
    .clk        (clk),
    .rst        (rst),
    .zc_i       (zc),
    .tick_i     (tick),
    .edge_o     (edge_s),
    .interval_o (intv_s),
    .timeout_o  (tmo_s),
    .fault_o    (fault_s),
    .in_spec_o  (spec_s)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all_clear(string req);
    check(req, "edge_o", int'(edge_s), 0);
    check(req, "interval_o", int'(intv_s), 0);
    check(req, "timeout_o", int'(tmo_s), 0);
    check(req, "fault_o", int'(fault_s), 0);
    check(req, "in_spec_o", int'(spec_s), 0);
  endtask

  // Two toggles D cycles apart; the second strobe reports D-1 ticks when tick is held high.
  task automatic measure(int d, int exp_int, int exp_fault, int exp_spec, string req);
    @(negedge clk) zc = ~zc;
    repeat (d) @(negedge clk);
    zc = ~zc;
    @(negedge clk);
    check("R2", "edge_o before strobe", int'(edge_s), 0);
    @(negedge clk);
    check("R2", "edge_o strobe", int'(edge_s), 1);
    @(negedge clk);
    check("R2", "edge_o after strobe", int'(edge_s), 0);
    check(req, "interval_o", int'(intv_s), exp_int);
    check(req, "fault_o", int'(fault_s), exp_fault);
    check(req, "in_spec_o", int'(spec_s), exp_spec);
  endtask

  task automatic t_reset_and_first_edge();
    rst = 1'b1; zc = 1'b0; tick = 1'b1;
    repeat (4) @(negedge clk);
    check_all_clear("R1");
    rst = 1'b0;
    @(negedge clk);
    check_all_clear("R1");
    zc = 1'b1;                        // rising change
    @(negedge clk);
    @(negedge clk);
    check("R2", "rising strobe", int'(edge_s), 1);
    @(negedge clk);
    check("R2", "rising strobe width", int'(edge_s), 0);
    check("R10", "interval_o", int'(intv_s), 0);
    check("R10", "fault_o", int'(fault_s), 0);
    check("R10", "in_spec_o", int'(spec_s), 0);
  endtask

  task automatic t_windows();
    measure(101, 100, 0, 1, "R8");    // nominal
    measure(91, 90, 0, 1, "R8");      // acceptance lower bound
    measure(90, 89, 0, 0, "R8");      // just below
    measure(111, 110, 1, 1, "R8");    // acceptance upper bound, framing fault
    measure(112, 111, 1, 0, "R8");    // just above
    measure(103, 102, 0, 1, "R7");    // framing upper bound passes
    measure(104, 103, 1, 1, "R7");    // just above framing
    measure(73, 72, 0, 0, "R7");      // framing lower bound passes
    measure(72, 71, 1, 0, "R7");      // just below framing
    measure(86, 85, 0, 0, "R3");      // plain interval
  endtask

  task automatic t_no_tick();
    tick = 1'b0;
    measure(50, 0, 1, 0, "R4");
    tick = 1'b1;
  endtask

  task automatic t_timeout_then_late_edge();
    measure(101, 100, 0, 1, "R3");    // count visible as 0 at this negedge
    repeat (299) @(negedge clk);
    check("R6", "timeout_o one short", int'(tmo_s), 0);
    @(negedge clk);
    check("R6", "timeout_o at limit", int'(tmo_s), 1);
    check("R9", "in_spec_o before clear", int'(spec_s), 1);
    @(negedge clk);
    check("R9", "in_spec_o after timeout", int'(spec_s), 0);
    check("R3", "interval_o held", int'(intv_s), 100);
    repeat (20) @(negedge clk);
    zc = ~zc;
    @(negedge clk);
    @(negedge clk);
    check("R6", "timeout_o in strobe cycle", int'(tmo_s), 1);
    @(negedge clk);
    check("R6", "timeout_o after strobe", int'(tmo_s), 0);
    check("R5", "saturated interval", int'(intv_s), TMO);
    check("R5", "fault_o", int'(fault_s), 1);
  endtask

  task automatic t_same_cycle();
    @(negedge clk) zc = ~zc;
    repeat (TMO + 1) @(negedge clk);
    zc = ~zc;
    @(negedge clk);
    @(negedge clk);
    check("R11", "edge_o", int'(edge_s), 1);
    check("R11", "timeout_o", int'(tmo_s), 1);
    @(negedge clk);
    check("R11", "timeout_o cleared", int'(tmo_s), 0);
    check("R11", "interval_o", int'(intv_s), TMO);
    check("R11", "fault_o", int'(fault_s), 1);
    check("R11", "in_spec_o", int'(spec_s), 0);
  endtask

  task automatic t_falling_only();
    if (zc == 1'b0) begin
      @(negedge clk) zc = 1'b1;
      repeat (5) @(negedge clk);
    end
    @(negedge clk) zc = 1'b0;         // falling change
    @(negedge clk);
    @(negedge clk);
    check("R2", "falling strobe", int'(edge_s), 1);
    @(negedge clk);
    check("R2", "falling strobe width", int'(edge_s), 0);
  endtask

  task automatic t_mid_reset();
    measure(101, 100, 0, 1, "R8");
    @(negedge clk) begin rst = 1'b1; zc = 1'b0; end
    repeat (2) @(negedge clk);
    check_all_clear("R1");
    rst = 1'b0;
    @(negedge clk);
    zc = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", "interval_o after reset", int'(intv_s), 0);
    check("R10", "in_spec_o after reset", int'(spec_s), 0);
    measure(96, 95, 0, 1, "R8");
  endtask

  initial begin
    t_reset_and_first_edge();
    t_windows();
    t_no_tick();
    t_timeout_then_late_edge();
    t_same_cycle();
    t_falling_only();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule